// File: doc/BRIEF.md
# Miss-Delta Stride Prefetcher

This block turns the stream of data-cache miss physical addresses on each load pipe into prefetch requests. Every pipe has its own generator. The generator keeps the two most recent miss addresses and treats their difference as the stride. When the next miss arrives, the block adds that stride to the new address, which gives the first prefetch candidate. A candidate goes out only if it lands in a 64-byte line other than the one that just missed.

A shared degree setting controls how many candidates each miss produces. After the first candidate, the block adds the stride again once for each extra step. Each generator hands its requests to the miss-request path through a valid/ready handshake. A request held back by the consumer stalls the sequence in place. A fresh miss on the same pipe abandons whatever remains of the current sequence and starts a new one.

Cache storage, the miss buffer and arbitration against demand misses belong to the surrounding logic.

Top module: `miss_delta_prefetcher`

## Requirements
- R1: While reset is held, and in the cycle after it is released, every `pf_vld` bit is 0 and each pipe's miss history is empty.
- R2: A miss produces no prefetch unless two earlier misses on the same pipe were captured since reset. The first two misses after reset never produce one.
- R3: When a miss with address M is captured at a clock edge, the stride D is the latest earlier miss address minus the one before it. If the sequence issues, the first candidate M + D appears on `pf_pa` right after that edge.
- R4: A candidate whose address bits [AW-1:6] equal those of the triggering miss is not issued. The sequence still moves past it, taking one cycle.
- R5: With degree n (an unsigned `degree_cfg` value), candidate k is M + k·D for k = 1..n, presented in increasing k. Degree 0 issues nothing.
- R6: A stride of zero suppresses the whole sequence.
- R7: While `pf_vld` is 1 and `pf_rdy` is 0, and no new miss arrives on that pipe, the next cycle keeps `pf_vld` at 1 and `pf_pa` unchanged.
- R8: A miss arriving while a sequence is active drops the remaining candidates. It restarts from the new miss, using the stride learned from the two misses before it.
- R9: Each pipe's history and sequence are independent. Misses on one pipe never cause requests, or change history, on another.
- R10: Address arithmetic wraps modulo 2^AW, so a negative stride produces descending prefetch addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_vld | input | NUM_PIPES | Miss-address valid, one bit per pipe |
| miss_pa | input | NUM_PIPES*AW | Miss physical addresses, pipe p at [p*AW +: AW] |
| degree_cfg | input | DEG_W | Prefetch degree, shared by all pipes |
| pf_rdy | input | NUM_PIPES | Consumer accepts the prefetch on that pipe |
| pf_vld | output | NUM_PIPES | Prefetch request valid per pipe |
| pf_pa | output | NUM_PIPES*AW | Prefetch addresses, pipe p at [p*AW +: AW] |

## Verification
Several kinds of three-miss stream are driven into one pipe with a range of degrees:
- **Line-sized and larger positive strides.** These give the plain iteration order.
- **Sub-line strides.** Some candidates stay in the missed line and must be skipped while others go out, which separates the line filter from the degree counter.
- **A negative stride.** This exposes signed wrap-around.
- **A repeated address, and degree 0.** Both must stay silent, which shows suppression is distinct from a filtered candidate.

Directed sequences cover three more behaviours:
- backpressure holding an address;
- a miss arriving mid-sequence, where the restart address reveals which stride was learned;
- traffic on the second pipe alone, which confirms the pipes are isolated.

// File: rtl/mdp_pkg.sv
// Shared types for the miss-delta prefetcher.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mdp_pkg;
    // How many valid entries the two-deep miss history holds.
    typedef enum logic [1:0] {
        HIST_EMPTY = 2'd0,
        HIST_ONE   = 2'd1,
        HIST_FULL  = 2'd2
    } hist_fill_e;
endpackage

// File: rtl/mdp_history.sv
// Two-deep miss history for one pipe. It shifts in each captured miss
// address and reports the stride between the last two entries. The stride
// may be used only once both entries are filled and it is non-zero.
// Assumes cap_vld lasts one cycle per miss.
module mdp_history
    import mdp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_vld,
    input  logic [AW-1:0] cap_pa,
    output logic [AW-1:0] stride,
    output logic          stride_ok,
    output hist_fill_e    fill
);
    logic [AW-1:0] last_pa;
    logic [AW-1:0] older_pa;

    // Shift the new miss into the history and count the fill level up to full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pa  <= '0;
            older_pa <= '0;
            fill     <= HIST_EMPTY;
        end else if (cap_vld) begin
            older_pa <= last_pa;
            last_pa  <= cap_pa;
            if (fill == HIST_EMPTY)
                fill <= HIST_ONE;
            else
                fill <= HIST_FULL;
        end
    end

    // Stride is the newer entry minus the older one (wraps modulo 2^AW).
    always_comb begin
        stride    = last_pa - older_pa;
        stride_ok = (fill == HIST_FULL) && (stride != '0);
    end

    // R2: the history is never full one cycle after a reset with no capture
    // R2
    history_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !$past(cap_vld)) |-> (fill == HIST_EMPTY));
endmodule

// File: rtl/mdp_engine.sv
// Loopback candidate generator for one pipe. A start loads miss + stride.
// Each later step adds the stride again, until the latched degree is used
// up. A candidate in the missed line is skipped without output. A stalled
// output holds its address. A new start overrides everything.
module mdp_engine #(
    parameter int AW     = 32,
    parameter int DEG_W  = 3,
    parameter int LINE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_ok,
    input  logic [AW-1:0]    start_pa,
    input  logic [AW-1:0]    stride,
    input  logic [DEG_W-1:0] degree,
    input  logic             out_rdy,
    output logic             out_vld,
    output logic [AW-1:0]    out_pa
);
    localparam int TAG_W = AW - LINE_W;

    logic             active;
    logic [AW-1:0]    cand;
    logic [AW-1:0]    step;
    logic [DEG_W-1:0] left;
    logic [TAG_W-1:0] home_tag;
    logic             crosses;
    logic             advance;

    // Decide whether the current candidate may go out and whether to step.
    always_comb begin
        crosses = cand[AW-1:LINE_W] != home_tag;
        out_vld = active && crosses;
        out_pa  = cand;
        advance = active && (out_rdy || !crosses);
    end

    // Start a new sequence on a miss, or loop the adder on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cand     <= '0;
            step     <= '0;
            left     <= '0;
            home_tag <= '0;
        end else if (start) begin
            active   <= start_ok && (degree != '0);
            cand     <= start_pa + stride;
            step     <= stride;
            left     <= degree;
            home_tag <= start_pa[AW-1:LINE_W];
        end else if (advance) begin
            if (left == DEG_W'(1)) begin
                active <= 1'b0;
            end else begin
                left <= left - DEG_W'(1);
                cand <= cand + step;
            end
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy && !start) |=> (out_vld && $stable(out_pa)));
endmodule

// File: rtl/mdp_pipe.sv
// One load pipe's prefetcher: miss history feeding the loopback engine.
// Assumes a single miss per cycle on this pipe.
module mdp_pipe
    import mdp_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DEG_W  = 3,
    parameter int LINE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_vld,
    input  logic [AW-1:0]    miss_pa,
    input  logic [DEG_W-1:0] degree,
    input  logic             pf_rdy,
    output logic             pf_vld,
    output logic [AW-1:0]    pf_pa
);
    logic [AW-1:0] stride;
    logic          stride_ok;
    hist_fill_e    fill;

    mdp_history #(.AW(AW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_vld  (miss_vld),
        .cap_pa   (miss_pa),
        .stride   (stride),
        .stride_ok(stride_ok),
        .fill     (fill)
    );

    mdp_engine #(.AW(AW), .DEG_W(DEG_W), .LINE_W(LINE_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (miss_vld),
        .start_ok(stride_ok),
        .start_pa(miss_pa),
        .stride  (stride),
        .degree  (degree),
        .out_rdy (pf_rdy),
        .out_vld (pf_vld),
        .out_pa  (pf_pa)
    );

    // Checker state: the line of the last miss and handshakes since it.
    logic [AW-LINE_W-1:0] chk_line;
    logic [DEG_W:0]       chk_hs;
    logic [DEG_W-1:0]     chk_deg;

    // Track the triggering line and count accepted prefetches per miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_line <= '0;
            chk_hs   <= '0;
            chk_deg  <= '0;
        end else if (miss_vld) begin
            chk_line <= miss_pa[AW-1:LINE_W];
            chk_hs   <= '0;
            chk_deg  <= degree;
        end else if (pf_vld && pf_rdy) begin
            chk_hs <= chk_hs + 1'b1;
        end
    end

    // R2
    warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_vld && fill != HIST_FULL) |=> !pf_vld);
    // R6
    zero_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_vld && stride == '0) |=> !pf_vld);
    // R4
    other_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_vld |-> (pf_pa[AW-1:LINE_W] != chk_line));
    // R5
    degree_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hs <= {1'b0, chk_deg});
endmodule

// File: rtl/miss_delta_prefetcher.sv
// Miss-delta prefetcher: one independent generator per load pipe. Buses
// are flattened, pipe p at [p*AW +: AW]. The degree setting is shared.
// Assumes 2^LINE_W-byte cache lines.
module miss_delta_prefetcher #(
    parameter int NUM_PIPES  = 2,
    parameter int AW         = 32,
    parameter int DEG_W      = 3,
    parameter int LINE_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_PIPES-1:0]    miss_vld,
    input  logic [NUM_PIPES*AW-1:0] miss_pa,
    input  logic [DEG_W-1:0]        degree_cfg,
    input  logic [NUM_PIPES-1:0]    pf_rdy,
    output logic [NUM_PIPES-1:0]    pf_vld,
    output logic [NUM_PIPES*AW-1:0] pf_pa
);
    localparam int LINE_W = $clog2(LINE_BYTES);

    // One generator per pipe, sharing only clock, reset and degree.
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        mdp_pipe #(.AW(AW), .DEG_W(DEG_W), .LINE_W(LINE_W)) u_pipe (
            .clk     (clk),
            .rst_n   (rst_n),
            .miss_vld(miss_vld[p]),
            .miss_pa (miss_pa[p*AW +: AW]),
            .degree  (degree_cfg),
            .pf_rdy  (pf_rdy[p]),
            .pf_vld  (pf_vld[p]),
            .pf_pa   (pf_pa[p*AW +: AW])
        );
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (pf_vld == '0));
endmodule

// File: tb/miss_delta_prefetcher_test.sv
`timescale 1ns/1ps
module miss_delta_prefetcher_test;
    localparam int AW = 32;
    localparam int NP = 2;
    localparam int DW = 3;

    typedef struct packed {
        logic [AW-1:0] a0;
        logic [AW-1:0] a1;
        logic [AW-1:0] a2;
        logic [DW-1:0] deg;
        logic [3:0]    n_exp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'h0000_1040, 32'h0000_1080, 3'd1, 4'd1}, // line stride
        '{32'h0000_2000, 32'h0000_2100, 32'h0000_2200, 3'd3, 4'd3}, // big stride, degree 3
        '{32'h0000_3000, 32'h0000_3008, 32'h0000_3010, 3'd1, 4'd0}, // stays in line
        '{32'h0000_3000, 32'h0000_3010, 32'h0000_3020, 3'd4, 4'd3}, // first skipped
        '{32'h0000_8000, 32'h0000_7F80, 32'h0000_7F00, 3'd2, 4'd2}, // negative stride
        '{32'h0000_5000, 32'h0000_5000, 32'h0000_6000, 3'd3, 4'd0}, // zero stride
        '{32'h0000_1000, 32'h0000_1040, 32'h0000_1080, 3'd0, 4'd0}  // degree 0
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NP-1:0]     miss_vld;
    logic [NP*AW-1:0]  miss_pa;
    logic [DW-1:0]     degree_cfg;
    logic [NP-1:0]     pf_rdy;
    logic [NP-1:0]     pf_vld;
    logic [NP*AW-1:0]  pf_pa;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    miss_delta_prefetcher #(.NUM_PIPES(NP), .AW(AW), .DEG_W(DW), .LINE_BYTES(64)) uut (
        .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .miss_pa(miss_pa),
        .degree_cfg(degree_cfg), .pf_rdy(pf_rdy), .pf_vld(pf_vld), .pf_pa(pf_pa)
    );

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; miss_vld = '0; miss_pa = '0; pf_rdy = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one miss at the current negedge; return at the following negedge.
    task automatic miss(input int p, input logic [AW-1:0] a);
        miss_vld[p] = 1'b1;
        miss_pa[p*AW +: AW] = a;
        @(negedge clk);
        miss_vld[p] = 1'b0;
    endtask

    function automatic logic [AW-1:0] pa0();
        return pf_pa[AW-1:0];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        degree_cfg = 3'd1;
        rst_n = 1'b0; miss_vld = '0; miss_pa = '0; pf_rdy = '1;
        @(negedge clk);
        // R1: outputs idle during reset
        chk(pf_vld == '0, "R1 idle in reset", AW'(pf_vld), 0);
        do_reset();
        chk(pf_vld == '0, "R1 idle after reset", AW'(pf_vld), 0);

        // Vector table: three misses, then collect the whole sequence.
        foreach (VECS[i]) begin
            logic [AW-1:0] d;
            logic [AW-1:0] exp_a [8];
            int ne;
            int n;
            d  = VECS[i].a1 - VECS[i].a0;
            ne = 0;
            if (d != '0)
                for (int k = 1; k <= int'(VECS[i].deg); k++) begin
                    logic [AW-1:0] c;
                    c = VECS[i].a2 + AW'(k) * d;
                    if (c[AW-1:6] != VECS[i].a2[AW-1:6]) begin
                        exp_a[ne] = c;
                        ne++;
                    end
                end
            do_reset();
            degree_cfg = VECS[i].deg;
            miss(0, VECS[i].a0);
            chk(!pf_vld[0], "R2 R1 no prefetch after first miss", AW'(pf_vld[0]), 0);
            miss(0, VECS[i].a1);
            chk(!pf_vld[0], "R2 no prefetch after second miss", AW'(pf_vld[0]), 0);
            miss(0, VECS[i].a2);
            n = 0;
            for (int c = 0; c <= int'(VECS[i].deg); c++) begin
                if (pf_vld[0]) begin
                    if (n < ne)
                        chk(pa0() == exp_a[n], "R3 R4 R5 R10 candidate address", pa0(), exp_a[n]);
                    else
                        chk(1'b0, "R4 R5 R6 extra prefetch", pa0(), 0);
                    n++;
                end
                @(negedge clk);
            end
            chk(n == int'(VECS[i].n_exp), "R4 R5 R6 issued count", AW'(n), AW'(VECS[i].n_exp));
            chk(!pf_vld[0], "R5 sequence ends", AW'(pf_vld[0]), 0);
        end

        // R7: backpressure holds the address
        do_reset();
        degree_cfg = 3'd3;
        pf_rdy[0] = 1'b0;
        miss(0, 32'h2000); miss(0, 32'h2100); miss(0, 32'h2200);
        for (int c = 0; c < 3; c++) begin
            chk(pf_vld[0] && pa0() == 32'h2300, "R7 stalled hold", pa0(), 32'h2300);
            @(negedge clk);
        end
        pf_rdy[0] = 1'b1;
        chk(pf_vld[0] && pa0() == 32'h2300, "R7 release first", pa0(), 32'h2300);
        @(negedge clk);
        chk(pf_vld[0] && pa0() == 32'h2400, "R7 second after release", pa0(), 32'h2400);
        @(negedge clk);
        chk(pf_vld[0] && pa0() == 32'h2500, "R7 third after release", pa0(), 32'h2500);
        @(negedge clk);
        chk(!pf_vld[0], "R7 done", AW'(pf_vld[0]), 0);

        // R8: new miss mid-sequence restarts with stride 0x100
        do_reset();
        degree_cfg = 3'd4;
        miss(0, 32'h2000); miss(0, 32'h2100); miss(0, 32'h2200);
        chk(pf_vld[0] && pa0() == 32'h2300, "R8 first of old sequence", pa0(), 32'h2300);
        miss(0, 32'h2800);
        for (int k = 1; k <= 4; k++) begin
            chk(pf_vld[0] && pa0() == 32'h2800 + AW'(k) * 32'h100, "R8 restarted sequence",
                pa0(), 32'h2800 + AW'(k) * 32'h100);
            @(negedge clk);
        end
        chk(!pf_vld[0], "R8 restart ends", AW'(pf_vld[0]), 0);

        // R9: pipe 1 alone; pipe 0 stays silent and its history empty
        do_reset();
        degree_cfg = 3'd2;
        miss(1, 32'h9000); miss(1, 32'h9080); miss(1, 32'h9100);
        chk(pf_vld[1] && pf_pa[2*AW-1:AW] == 32'h9180, "R9 pipe1 first", pf_pa[2*AW-1:AW], 32'h9180);
        chk(!pf_vld[0], "R9 pipe0 quiet", AW'(pf_vld[0]), 0);
        @(negedge clk);
        chk(pf_vld[1] && pf_pa[2*AW-1:AW] == 32'h9200, "R9 pipe1 second", pf_pa[2*AW-1:AW], 32'h9200);
        @(negedge clk);
        miss(0, 32'h4000); miss(0, 32'h4100);
        chk(!pf_vld[0], "R9 pipe0 history untouched", AW'(pf_vld[0]), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule